// File: doc/BRIEF.md
# Relay-Feedback Compensator Auto-Tuner

This block runs the tuning sequence of a digital voltage-mode converter loop. On a start command it takes the loop away from the normal compensator and closes it through a sign-only relay followed by an integrator. The relay and integrator push the output into a self-sustained oscillation. The block times that oscillation from the error samples alone, using only the spacing of the error's rising sign changes and never its size. The first oscillation runs at the power stage's resonance, and its period sets the first compensator zero through a table.

In a second phase the relay path adds a lead term scaled by the second-zero code. That code moves by one step per measurement until the measured period equals the target crossover period. A gain code then follows from the chosen bandwidth class and the two zero codes. The loop is then handed back to the normal compensator, which reads the three codes. If no rising sign change arrives within a programmable number of samples, or the second-zero search runs too long, the block stops. It raises an error flag and presents default codes.

Top module: `relay_autotuner`

## Requirements
- R1: After reset, and whenever no tuning is in progress, `relay_sel_o` is 0 and `ctrl_o` is 0. After reset the codes are zero1=20, zero2=32, gain=16, `period_o` is 0, and `done_o` and `error_o` are 0.
- R2: While tuning, each valid sample moves an integrator by +1 if `err_i` >= 0 and by -1 if `err_i` < 0. The integrator saturates at +255 and -255 and is cleared at start. In the first phase `ctrl_o` equals the integrator.
- R3: A period is the number of valid samples between two samples at which the error goes from negative to non-negative. After each measurement restart, the first such change only arms the counter. The next 4 periods are discarded. The reported period is the floor of the mean of the following 8.
- R4: At the end of the first phase, zero1 = 63 - 4*min(floor(P/4), 15), where P is the measured period.
- R5: zero2 starts at 32 each run. After each second-phase measurement that differs from `target_per_i`, zero2 rises by 1 if the measured period is longer than the target and falls by 1 if it is shorter, saturating at 0 and 63.
- R6: When a second-phase measurement equals `target_per_i`, the gain code becomes clamp(8*(bw_sel_i+1) + floor(zero1/4) - floor(zero2/8), 0, 63). `done_o` then rises, and the relay path is released.
- R7: If a mismatch arrives after 64 zero2 steps have already been made, tuning aborts. `error_o` rises and the codes return to 20, 32 and 16.
- R8: If `timeout_i` consecutive valid samples pass without a rising sign change, tuning aborts as in R7. With `timeout_i`=20, 19 such samples do not abort and the 20th does.
- R9: `start_i` is ignored while tuning. From idle, done or error it begins a new run and clears `done_o` and `error_o`.
- R10: The results do not depend on the error magnitude, only on its sign pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a tuning run |
| err_vld_i | input | 1 | Error sample valid strobe |
| err_i | input | 12 | Signed error sample |
| target_per_i | input | 16 | Desired crossover period in samples |
| timeout_i | input | 16 | Samples allowed without a rising sign change |
| bw_sel_i | input | 2 | Target bandwidth class |
| relay_sel_o | output | 1 | 1: relay path drives the modulator |
| ctrl_o | output | 10 | Signed relay-path control word |
| period_o | output | 16 | Last measured oscillation period |
| zero1_o | output | 6 | First zero code |
| zero2_o | output | 6 | Second zero code |
| gain_o | output | 6 | Gain code |
| done_o | output | 1 | Tuning finished successfully |
| error_o | output | 1 | Tuning aborted |

## Verification
Several properties are checked on every cycle by the assertions. The integrator stays within its saturation bounds and moves by at most one per sample. zero2 moves by at most one step per cycle while tuning. Done and error are never high together, and neither is high while the relay path is selected. The iteration count stays within its limit, and an abort always shows the default codes. Other behaviours can only be shown by the bench scenarios: the averaged period values, the table outputs for zero1 and gain, the direction of the zero2 search, the exact timeout boundary, and the insensitivity to error magnitude.

// File: rtl/relay_tune_pkg.sv
package relay_tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RES,
        ST_XOVER,
        ST_DONE,
        ST_FAIL
    } tune_st_e;
endpackage

// File: rtl/rt_period_meter.sv
module rt_period_meter #(
    parameter int PER_W    = 16,
    parameter int SETTLE_N = 4,
    parameter int AVG_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             vld_i,
    input  logic             neg_i,
    input  logic [PER_W-1:0] timeout_i,
    output logic             done_o,
    output logic [PER_W-1:0] per_o,
    output logic             tout_o
);
    localparam int AVG_N   = 1 << AVG_LOG2;
    localparam int TOTAL_N = SETTLE_N + AVG_N;
    localparam int EDGE_W  = $clog2(TOTAL_N + 1);
    localparam int SUM_W   = PER_W + AVG_LOG2;
    localparam logic [EDGE_W-1:0] SETTLE_E = EDGE_W'(SETTLE_N);
    localparam logic [EDGE_W-1:0] LAST_E   = EDGE_W'(TOTAL_N - 1);

    typedef struct packed {
        logic              run;
        logic              prev_neg;
        logic              armed;
        logic [PER_W-1:0]  cnt;
        logic [EDGE_W-1:0] edges;
        logic [SUM_W-1:0]  sum;
        logic              done;
        logic [PER_W-1:0]  per;
        logic              tout;
    } meter_t;

    meter_t meter_d, meter_q;
    logic             rise;
    logic [PER_W-1:0] cnt_inc;
    logic [SUM_W-1:0] sum_n;

    always_comb begin
        meter_d = meter_q;
        meter_d.done = 1'b0;
        meter_d.tout = 1'b0;
        rise    = meter_q.prev_neg && !neg_i;
        cnt_inc = (meter_q.cnt == '1) ? meter_q.cnt : meter_q.cnt + 1'b1;
        sum_n   = meter_q.sum + SUM_W'(cnt_inc);
        if (clear_i) begin
            meter_d.run      = 1'b1;
            meter_d.prev_neg = 1'b0;
            meter_d.armed    = 1'b0;
            meter_d.cnt      = '0;
            meter_d.edges    = '0;
            meter_d.sum      = '0;
        end else if (vld_i && meter_q.run) begin
            meter_d.prev_neg = neg_i;
            if (rise) begin
                meter_d.cnt = '0;
                if (!meter_q.armed) begin
                    meter_d.armed = 1'b1;
                end else begin
                    meter_d.edges = meter_q.edges + 1'b1;
                    if (meter_q.edges >= SETTLE_E) begin
                        meter_d.sum = sum_n;
                    end
                    if (meter_q.edges == LAST_E) begin
                        meter_d.done = 1'b1;
                        meter_d.per  = PER_W'(sum_n >> AVG_LOG2);
                        meter_d.run  = 1'b0;
                    end
                end
            end else begin
                meter_d.cnt = cnt_inc;
                if (cnt_inc >= timeout_i) begin
                    meter_d.tout = 1'b1;
                    meter_d.run  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meter_q <= '0;
        end else begin
            meter_q <= meter_d;
        end
    end

    assign done_o = meter_q.done;
    assign per_o  = meter_q.per;
    assign tout_o = meter_q.tout;

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        meter_q.done |=> !meter_q.done);
    assert_done_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        meter_q.done |-> (meter_q.per != '0));
    assert_tout_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(meter_q.done && meter_q.tout));
endmodule

// File: rtl/rt_relay_integ.sv
module rt_relay_integ #(
    parameter int CTRL_W = 10,
    parameter int CODE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     en_i,
    input  logic                     vld_i,
    input  logic                     neg_i,
    input  logic                     lead_en_i,
    input  logic [CODE_W-1:0]        z2_i,
    output logic signed [CTRL_W-1:0] ctrl_o
);
    localparam logic signed [CTRL_W-1:0] LIM_P = CTRL_W'((1 << (CTRL_W - 2)) - 1);
    localparam logic signed [CTRL_W-1:0] LIM_N = -LIM_P;

    typedef struct packed {
        logic [CTRL_W-1:0] integ;
        logic              relay_neg;
    } integ_t;

    integ_t integ_d, integ_q;
    logic signed [CTRL_W-1:0] acc;
    logic signed [CTRL_W-1:0] lead;

    always_comb begin
        integ_d = integ_q;
        acc     = $signed(integ_q.integ);
        if (clear_i) begin
            integ_d.integ     = '0;
            integ_d.relay_neg = 1'b0;
        end else if (en_i && vld_i) begin
            integ_d.relay_neg = neg_i;
            if (neg_i) begin
                integ_d.integ = (acc == LIM_N) ? acc : acc - 1'b1;
            end else begin
                integ_d.integ = (acc == LIM_P) ? acc : acc + 1'b1;
            end
        end
    end

    always_comb begin
        lead = $signed({{(CTRL_W - CODE_W){1'b0}}, z2_i});
        if (!en_i) begin
            ctrl_o = '0;
        end else if (lead_en_i) begin
            ctrl_o = acc + (integ_q.relay_neg ? -lead : lead);
        end else begin
            ctrl_o = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ_q <= '0;
        end else begin
            integ_q <= integ_d;
        end
    end

    assert_integ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(integ_q.integ) <= LIM_P) && ($signed(integ_q.integ) >= LIM_N));
    assert_integ_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && vld_i && !clear_i) |=>
            ((integ_q.integ == $past(integ_q.integ)) ||
             (integ_q.integ == $past(integ_q.integ) + 1'b1) ||
             (integ_q.integ == $past(integ_q.integ) - 1'b1)));
endmodule

// File: rtl/rt_coef_lut.sv
module rt_coef_lut #(
    parameter int PER_W     = 16,
    parameter int CODE_W    = 6,
    parameter int BW_W      = 2,
    parameter int BUCKET_SH = 2,
    parameter int BUCKETS   = 16,
    parameter int GAIN_STEP = 8
) (
    input  logic [PER_W-1:0]  per_i,
    input  logic [BW_W-1:0]   bw_i,
    input  logic [CODE_W-1:0] z1_i,
    input  logic [CODE_W-1:0] z2_i,
    output logic [CODE_W-1:0] z1_o,
    output logic [CODE_W-1:0] gain_o
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int Z1_STEP  = (1 << CODE_W) / BUCKETS;
    localparam int BW_N     = 1 << BW_W;
    localparam int BASE_W   = CODE_W + BW_W + 1;

    logic [BASE_W-1:0] base_tbl [BW_N];
    logic [PER_W-1:0]  bucket_raw;
    int                bucket;
    int                gsum;

    for (genvar i = 0; i < BW_N; i++) begin : g_base
        assign base_tbl[i] = BASE_W'((i + 1) * GAIN_STEP);
    end

    always_comb begin
        bucket_raw = per_i >> BUCKET_SH;
        bucket     = (bucket_raw > PER_W'(BUCKETS - 1)) ? (BUCKETS - 1) : int'(bucket_raw);
        z1_o       = CODE_W'(CODE_MAX - Z1_STEP * bucket);
    end

    always_comb begin
        gsum = int'(base_tbl[bw_i]) + int'(z1_i >> 2) - int'(z2_i >> 3);
        if (gsum < 0) begin
            gain_o = '0;
        end else if (gsum > CODE_MAX) begin
            gain_o = CODE_W'(CODE_MAX);
        end else begin
            gain_o = CODE_W'(gsum);
        end
    end
endmodule

// File: rtl/relay_autotuner.sv
module relay_autotuner
    import relay_tune_pkg::*;
#(
    parameter int ERR_W     = 12,
    parameter int CTRL_W    = 10,
    parameter int PER_W     = 16,
    parameter int CODE_W    = 6,
    parameter int BW_W      = 2,
    parameter int SETTLE_N  = 4,
    parameter int AVG_LOG2  = 3,
    parameter int MAX_ITER  = 64,
    parameter int Z2_INIT   = 32,
    parameter int DEF_Z1    = 20,
    parameter int DEF_GAIN  = 16,
    parameter int BUCKET_SH = 2,
    parameter int Z1_BUCKETS = 16,
    parameter int GAIN_STEP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     err_vld_i,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic [PER_W-1:0]         target_per_i,
    input  logic [PER_W-1:0]         timeout_i,
    input  logic [BW_W-1:0]          bw_sel_i,
    output logic                     relay_sel_o,
    output logic signed [CTRL_W-1:0] ctrl_o,
    output logic [PER_W-1:0]         period_o,
    output logic [CODE_W-1:0]        zero1_o,
    output logic [CODE_W-1:0]        zero2_o,
    output logic [CODE_W-1:0]        gain_o,
    output logic                     done_o,
    output logic                     error_o
);
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam logic [ITER_W-1:0] ITER_LIM = ITER_W'(MAX_ITER);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;
    localparam logic [CODE_W-1:0] Z2_RST   = CODE_W'(Z2_INIT);
    localparam logic [CODE_W-1:0] Z1_RST   = CODE_W'(DEF_Z1);
    localparam logic [CODE_W-1:0] G_RST    = CODE_W'(DEF_GAIN);

    typedef struct packed {
        tune_st_e          st;
        logic [CODE_W-1:0] z1;
        logic [CODE_W-1:0] z2;
        logic [CODE_W-1:0] gain;
        logic [PER_W-1:0]  per;
        logic [ITER_W-1:0] iter;
        logic              done;
        logic              fail;
        logic              clr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              err_neg;
    logic              meas_done;
    logic [PER_W-1:0]  meas_per;
    logic              meas_tout;
    logic [CODE_W-1:0] z1_lut;
    logic [CODE_W-1:0] gain_lut;
    logic              tuning;

    assign err_neg = (err_i < 0);
    assign tuning  = (seq_q.st == ST_RES) || (seq_q.st == ST_XOVER);

    rt_period_meter #(
        .PER_W   (PER_W),
        .SETTLE_N(SETTLE_N),
        .AVG_LOG2(AVG_LOG2)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (seq_q.clr),
        .vld_i    (err_vld_i && tuning),
        .neg_i    (err_neg),
        .timeout_i(timeout_i),
        .done_o   (meas_done),
        .per_o    (meas_per),
        .tout_o   (meas_tout)
    );

    rt_relay_integ #(
        .CTRL_W(CTRL_W),
        .CODE_W(CODE_W)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (seq_q.clr && (seq_q.st == ST_RES)),
        .en_i     (tuning),
        .vld_i    (err_vld_i),
        .neg_i    (err_neg),
        .lead_en_i(seq_q.st == ST_XOVER),
        .z2_i     (seq_q.z2),
        .ctrl_o   (ctrl_o)
    );

    rt_coef_lut #(
        .PER_W    (PER_W),
        .CODE_W   (CODE_W),
        .BW_W     (BW_W),
        .BUCKET_SH(BUCKET_SH),
        .BUCKETS  (Z1_BUCKETS),
        .GAIN_STEP(GAIN_STEP)
    ) u_lut (
        .per_i (meas_per),
        .bw_i  (bw_sel_i),
        .z1_i  (seq_q.z1),
        .z2_i  (seq_q.z2),
        .z1_o  (z1_lut),
        .gain_o(gain_lut)
    );

    always_comb begin
        seq_d = seq_q;
        seq_d.clr = 1'b0;
        unique case (seq_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    seq_d.st   = ST_RES;
                    seq_d.clr  = 1'b1;
                    seq_d.z2   = Z2_RST;
                    seq_d.iter = '0;
                    seq_d.done = 1'b0;
                    seq_d.fail = 1'b0;
                end
            end
            ST_RES: begin
                if (meas_tout) begin
                    seq_d.st   = ST_FAIL;
                    seq_d.fail = 1'b1;
                    seq_d.z1   = Z1_RST;
                    seq_d.z2   = Z2_RST;
                    seq_d.gain = G_RST;
                end else if (meas_done) begin
                    seq_d.per = meas_per;
                    seq_d.z1  = z1_lut;
                    seq_d.st  = ST_XOVER;
                    seq_d.clr = 1'b1;
                end
            end
            ST_XOVER: begin
                if (meas_tout) begin
                    seq_d.st   = ST_FAIL;
                    seq_d.fail = 1'b1;
                    seq_d.z1   = Z1_RST;
                    seq_d.z2   = Z2_RST;
                    seq_d.gain = G_RST;
                end else if (meas_done) begin
                    seq_d.per = meas_per;
                    if (meas_per == target_per_i) begin
                        seq_d.gain = gain_lut;
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_DONE;
                    end else if (seq_q.iter == ITER_LIM) begin
                        seq_d.st   = ST_FAIL;
                        seq_d.fail = 1'b1;
                        seq_d.z1   = Z1_RST;
                        seq_d.z2   = Z2_RST;
                        seq_d.gain = G_RST;
                    end else begin
                        if (meas_per > target_per_i) begin
                            seq_d.z2 = (seq_q.z2 == CODE_TOP) ? seq_q.z2 : seq_q.z2 + 1'b1;
                        end else begin
                            seq_d.z2 = (seq_q.z2 == '0) ? seq_q.z2 : seq_q.z2 - 1'b1;
                        end
                        seq_d.iter = seq_q.iter + 1'b1;
                        seq_d.clr  = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.z1   <= Z1_RST;
            seq_q.z2   <= Z2_RST;
            seq_q.gain <= G_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign relay_sel_o = tuning;
    assign period_o    = seq_q.per;
    assign zero1_o     = seq_q.z1;
    assign zero2_o     = seq_q.z2;
    assign gain_o      = seq_q.gain;
    assign done_o      = seq_q.done;
    assign error_o     = seq_q.fail;

    assert_sel_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        relay_sel_o |-> (!done_o && !error_o));
    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
    assert_z2_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (relay_sel_o && $past(relay_sel_o)) |->
            ((zero2_o == $past(zero2_o)) ||
             (zero2_o == $past(zero2_o) + 1'b1) ||
             (zero2_o == $past(zero2_o) - 1'b1)));
    assert_iter_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.iter <= ITER_LIM);
    assert_fail_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> ((zero1_o == Z1_RST) && (zero2_o == Z2_RST) && (gain_o == G_RST)));
endmodule

// File: tb/relay_autotuner_test.sv
module relay_autotuner_test;
    localparam int Z2_INIT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        err_vld_i = 1'b0;
    logic signed [11:0] err_i = '0;
    logic [15:0] target_per_i = '0;
    logic [15:0] timeout_i = 16'd200;
    logic [1:0]  bw_sel_i = '0;
    logic        relay_sel_o;
    logic signed [9:0] ctrl_o;
    logic [15:0] period_o;
    logic [5:0]  zero1_o, zero2_o, gain_o;
    logic        done_o, error_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit fail;
        int per;
        int z1;
        int z2;
        int gain;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    relay_autotuner uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .err_vld_i(err_vld_i),
        .err_i(err_i), .target_per_i(target_per_i), .timeout_i(timeout_i),
        .bw_sel_i(bw_sel_i), .relay_sel_o(relay_sel_o), .ctrl_o(ctrl_o),
        .period_o(period_o), .zero1_o(zero1_o), .zero2_o(zero2_o),
        .gain_o(gain_o), .done_o(done_o), .error_o(error_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int z1_of(input int p);
        int b;
        b = p / 4;
        if (b > 15) b = 15;
        return 63 - 4 * b;
    endfunction

    function automatic int gain_of(input int bw, input int z1, input int z2);
        int g;
        g = 8 * (bw + 1) + z1 / 4 - z2 / 8;
        if (g < 0) g = 0;
        if (g > 63) g = 63;
        return g;
    endfunction

    // monitor: compares each finished run against the scoreboard
    bit prev_flag = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (done_o || error_o) && !prev_flag) begin
            if (exp_q.size() == 0) begin
                chk("R6", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.fail ? "R7" : "R6", {e.tag, " error flag"}, longint'(error_o), longint'(e.fail));
                chk("R3", {e.tag, " period"}, longint'(period_o), longint'(e.per));
                chk("R4", {e.tag, " zero1"}, longint'(zero1_o), longint'(e.z1));
                chk("R5", {e.tag, " zero2"}, longint'(zero2_o), longint'(e.z2));
                chk("R6", {e.tag, " gain"}, longint'(gain_o), longint'(e.gain));
            end
        end
        prev_flag <= done_o || error_o;
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic feed(input int n, input int val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            err_vld_i = 1'b1;
            err_i = 12'(val);
        end
        @(negedge clk) err_vld_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_tune(input string tag, input int p1, input int p2a, input int p2b,
                            input int tgt, input int bw, input int amp, input bit fail);
        exp_t e;
        int cur, k, n;
        bit ph2, sw;
        e.tag = tag;
        e.fail = fail;
        e.per = fail ? p2b : tgt;
        if (fail) begin
            e.z1 = 20; e.z2 = 32; e.gain = 16;
        end else begin
            e.z1 = z1_of(p1);
            e.z2 = Z2_INIT + ((p2a > tgt) ? 1 : ((p2a < tgt) ? -1 : 0));
            e.gain = gain_of(bw, e.z1, e.z2);
        end
        exp_q.push_back(e);
        target_per_i = 16'(tgt);
        bw_sel_i = 2'(bw);
        timeout_i = 16'd200;
        pulse_start();
        chk("R9", {tag, " relay selected after start"}, longint'(relay_sel_o), 1);
        ph2 = 0; sw = 0; cur = p1; k = 0; n = 0;
        while (!(done_o || error_o) && n < 30000) begin
            @(negedge clk);
            if (!ph2 && period_o == 16'(p1)) begin
                ph2 = 1; cur = p2a; k = 0;
            end
            if (ph2 && !sw && zero2_o != 6'(Z2_INIT)) begin
                sw = 1; cur = p2b; k = 0;
            end
            err_vld_i = 1'b1;
            err_i = (k < cur / 2) ? 12'(-amp) : 12'(amp);
            k = (k + 1) % cur;
            n++;
        end
        @(negedge clk) err_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {tag, " relay released"}, longint'(relay_sel_o), 0);
        chk("R1", {tag, " ctrl idle"}, longint'(ctrl_o), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset relay_sel", longint'(relay_sel_o), 0);
        chk("R1", "reset ctrl", longint'(ctrl_o), 0);
        chk("R1", "reset zero1", longint'(zero1_o), 20);
        chk("R1", "reset zero2", longint'(zero2_o), 32);
        chk("R1", "reset gain", longint'(gain_o), 16);
        chk("R1", "reset period", longint'(period_o), 0);
        chk("R1", "reset flags", longint'({done_o, error_o}), 0);

        run_tune("match", 24, 10, 10, 10, 1, 300, 0);          // R3 R4 R6
        run_tune("step_up", 16, 14, 10, 10, 2, 5, 0);          // R5 upward
        run_tune("step_down", 40, 8, 10, 10, 0, 900, 0);       // R5 downward
        run_tune("amp_small", 24, 10, 10, 10, 1, 1, 0);        // R10 same as match
        run_tune("amp_large", 24, 10, 10, 10, 1, 2000, 0);     // R10
        run_tune("iter_limit", 12, 6, 6, 20, 3, 50, 1);        // R7

        // R8 timeout boundary
        begin
            exp_t e;
            e.tag = "timeout"; e.fail = 1; e.per = 6; e.z1 = 20; e.z2 = 32; e.gain = 16;
            exp_q.push_back(e);
        end
        pulse_start();
        chk("R9", "flags cleared by start", longint'({done_o, error_o}), 0);
        timeout_i = 16'd20;
        feed(19, 7);
        chk("R8", "no abort after 19 samples", longint'(error_o), 0);
        chk("R8", "still tuning after 19 samples", longint'(relay_sel_o), 1);
        feed(1, 7);
        chk("R8", "abort on 20th sample", longint'(error_o), 1);

        // R2 integrator and R9 ignored start
        timeout_i = 16'd1000;
        pulse_start();
        feed(5, 3);
        chk("R2", "integrator after 5 positive", longint'(ctrl_o), 5);
        feed(300, 0);
        chk("R2", "integrator saturated", longint'(ctrl_o), 255);
        feed(1, -4);
        chk("R2", "integrator step down", longint'(ctrl_o), 254);
        pulse_start();
        chk("R9", "start ignored while tuning ctrl", longint'(ctrl_o), 254);
        chk("R9", "start ignored while tuning sel", longint'(relay_sel_o), 1);
        begin
            exp_t e;
            e.tag = "late_timeout"; e.fail = 1; e.per = 6; e.z1 = 20; e.z2 = 32; e.gain = 16;
            exp_q.push_back(e);
        end
        timeout_i = 16'd20;
        feed(1, -4);
        chk("R8", "abort after lowered timeout", longint'(error_o), 1);
        chk("R1", "ctrl zero after abort", longint'(ctrl_o), 0);
        chk("R6", "scoreboard drained", longint'(exp_q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule